// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks exception state alongside each instruction of a five-stage in-order pipeline and makes the trap decision at a single commit point, the memory stage. Each of the first three stages can flag a fault against the instruction it currently holds. These are a fetch address fault, an illegal opcode in decode and an arithmetic overflow in execute. The flag and its cause code ride down with the instruction. The memory stage can add a data address fault of its own. Asynchronous interrupt requests are only looked at when an instruction sits in the memory stage.

When the instruction at commit carries a fault, or an enabled interrupt is pending, the controller does four things. It does not let that instruction commit. It records the instruction's PC in the exception PC register and the reason in the cause register. It enters supervisor mode with interrupts masked. It kills every pipeline stage and steers fetch to a fixed handler address. A return-from-supervisor instruction reaching commit does the reverse: it leaves supervisor mode, unmasks interrupts, kills the younger instructions and steers fetch back to the saved exception PC. The rest of the datapath uses `commit_o` as its permission to write architectural state.

Top module: `exc_commit_ctrl`

## Requirements
- R1: After reset the exception PC reads 0, the cause reads 0 (none), interrupts are enabled, the mode is user (`sup_o` low), and `commit_o` and `flush_o` are low.
- R2: An instruction that reaches the memory stage with no fault, and with no enabled interrupt pending, raises `commit_o` in that cycle without `flush_o`. The exception PC and cause keep their values.
- R3: Cause codes are 1 for fetch fault, 2 for illegal opcode, 3 for overflow and 4 for data address fault. When one instruction collects several faults, the code recorded is the one from the earliest stage.
- R4: An interrupt request seen while interrupts are enabled and an instruction is at commit is taken ahead of any fault of that instruction, and it records cause 5.
- R5: On any trap, `commit_o` is low and `flush_o` is high with `redirect_pc_o` equal to `HANDLER_PC` in the commit cycle. From the next cycle the exception PC holds the PC of the instruction at commit, interrupts are disabled and `sup_o` is high.
- R6: While interrupts are disabled, an interrupt request has no effect. A fault-free instruction at commit still commits, and the cause is left as it was.
- R7: A return-from-supervisor instruction that commits raises `flush_o` with `redirect_pc_o` equal to the saved exception PC. From the next cycle interrupts are enabled and `sup_o` is low.
- R8: Instructions younger than the one at commit are killed on a flush. They never commit, and faults flagged against them later do not trap.
- R9: Bubbles carry no exception. Fault flags and interrupt requests raised while the relevant stage holds no instruction cause no trap and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | An instruction leaves fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| fetch_fault_i | input | 1 | Fetch address fault on the fetched instruction |
| dec_illegal_i | input | 1 | Illegal opcode for the instruction in decode |
| exe_ovf_i | input | 1 | Overflow for the instruction in execute |
| mem_fault_i | input | 1 | Data address fault for the instruction in memory |
| mem_sret_i | input | 1 | Instruction in memory is a return-from-supervisor |
| irq_i | input | 1 | External interrupt request (level) |
| commit_o | output | 1 | Instruction in memory commits this cycle |
| flush_o | output | 1 | Kill all stages and redirect fetch |
| redirect_pc_o | output | PC_W | Fetch target when flush_o is high |
| epc_o | output | PC_W | Exception PC register |
| cause_o | output | 3 | Cause register |
| int_en_o | output | 1 | Interrupts enabled |
| sup_o | output | 1 | Supervisor mode |

## Verification
The bench sweeps every combination of the four fault flags and the interrupt line on a lone instruction. A design with the stage priority reversed would record the later stage's code. One that ranked interrupts below faults would record a fault code instead of 5. After each trap the bench returns with a return-from-supervisor and checks that fetch is steered to the saved PC; a design that restored the wrong PC or left interrupts masked fails there. Further cases cover these faults:
- a masked interrupt that still traps;
- a younger instruction that survives a flush and traps on its own overflow;
- fault flags on bubbles that spuriously trap.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_FETCH   = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVF     = 3'd3,
    CAUSE_DADDR   = 3'd4,
    CAUSE_IRQ     = 3'd5
  } cause_e;

  localparam int NUM_TRACK = 3; // decode, execute, memory holding registers
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int     PC_W        = 32,
  parameter cause_e RAISE_CAUSE = CAUSE_NONE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill_i,
  input  logic            v_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            exc_i,
  input  cause_e          cause_i,
  input  logic            raise_i,
  output logic            v_o,
  output logic [PC_W-1:0] pc_o,
  output logic            exc_o,
  output cause_e          cause_o
);
  logic            v_q, v_n;
  logic [PC_W-1:0] pc_q;
  logic            exc_q, exc_n;
  cause_e          cause_q, cause_n;
  logic            pc_en;

  always_comb begin
    v_n     = v_i & ~kill_i;
    pc_en   = v_i & ~kill_i;
    exc_n   = v_n & (exc_i | raise_i);
    cause_n = CAUSE_NONE;
    if (v_n) begin
      if (exc_i)        cause_n = cause_i;   // older stage keeps priority
      else if (raise_i) cause_n = RAISE_CAUSE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      v_q     <= v_n;
      exc_q   <= exc_n;
      cause_q <= cause_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_i;
  end

  assign v_o     = v_q;
  assign pc_o    = pc_q;
  assign exc_o   = exc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m_v_i,
  input  logic [PC_W-1:0] m_pc_i,
  input  logic            m_exc_i,
  input  cause_e          m_cause_i,
  input  logic            mem_fault_i,
  input  logic            sret_i,
  input  logic            irq_i,
  output logic            commit_o,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output cause_e          cause_o,
  output logic            int_en_o,
  output logic            sup_o
);
  logic            irq_take, sync_take, trap, sret_take;
  logic [PC_W-1:0] epc_q;
  cause_e          cause_q, cause_n;
  logic            int_en_q, int_en_n, sup_q, sup_n;
  logic            status_en;

  always_comb begin
    irq_take  = m_v_i & irq_i & int_en_q;
    sync_take = m_v_i & (m_exc_i | mem_fault_i);
    trap      = irq_take | sync_take;
    sret_take = m_v_i & sret_i & ~trap;
    status_en = trap | sret_take;

    if (irq_take)     cause_n = CAUSE_IRQ;
    else if (m_exc_i) cause_n = m_cause_i;
    else              cause_n = CAUSE_DADDR;

    int_en_n = sret_take;
    sup_n    = trap;

    commit_o      = m_v_i & ~trap;
    flush_o       = status_en;
    redirect_pc_o = trap ? HANDLER_PC : epc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else if (trap) begin
      epc_q   <= m_pc_i;
      cause_q <= cause_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= 1'b1;
      sup_q    <= 1'b0;
    end else if (status_en) begin
      int_en_q <= int_en_n;
      sup_q    <= sup_n;
    end
  end

  assign epc_o    = epc_q;
  assign cause_o  = cause_q;
  assign int_en_o = int_en_q;
  assign sup_o    = sup_q;

  // R5
  trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> (!int_en_q && sup_q && epc_q == $past(m_pc_i)));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (cause_q == CAUSE_IRQ));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_v_i && irq_i && !int_en_q && !m_exc_i && !mem_fault_i) |-> commit_o);

  // R7
  sret_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sret_take |=> (int_en_q && !sup_q));
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_fault_i,
  input  logic            dec_illegal_i,
  input  logic            exe_ovf_i,
  input  logic            mem_fault_i,
  input  logic            mem_sret_i,
  input  logic            irq_i,
  output logic            commit_o,
  output logic            flush_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [2:0]      cause_o,
  output logic            int_en_o,
  output logic            sup_o
);
  localparam int LAST = NUM_TRACK;

  logic [LAST:0]           stg_v;
  logic [LAST:0]           stg_exc;
  logic [LAST:0][PC_W-1:0] stg_pc;
  cause_e                  stg_cause [0:LAST];
  logic [LAST-1:0]         raise;
  logic                    flush;
  cause_e                  cause_w;

  assign stg_v[0]     = fetch_valid_i;
  assign stg_pc[0]    = fetch_pc_i;
  assign stg_exc[0]   = 1'b0;
  assign stg_cause[0] = CAUSE_NONE;
  assign raise        = {exe_ovf_i, dec_illegal_i, fetch_fault_i};

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    exc_stage_reg #(
      .PC_W        (PC_W),
      .RAISE_CAUSE (cause_e'(3'(i)))
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill_i  (flush),
      .v_i     (stg_v[i-1]),
      .pc_i    (stg_pc[i-1]),
      .exc_i   (stg_exc[i-1]),
      .cause_i (stg_cause[i-1]),
      .raise_i (raise[i-1]),
      .v_o     (stg_v[i]),
      .pc_o    (stg_pc[i]),
      .exc_o   (stg_exc[i]),
      .cause_o (stg_cause[i])
    );
  end

  exc_commit_unit #(
    .PC_W       (PC_W),
    .HANDLER_PC (HANDLER_PC)
  ) u_commit (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_v_i         (stg_v[LAST]),
    .m_pc_i        (stg_pc[LAST]),
    .m_exc_i       (stg_exc[LAST]),
    .m_cause_i     (stg_cause[LAST]),
    .mem_fault_i   (mem_fault_i),
    .sret_i        (mem_sret_i),
    .irq_i         (irq_i),
    .commit_o      (commit_o),
    .flush_o       (flush),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_w),
    .int_en_o      (int_en_o),
    .sup_o         (sup_o)
  );

  assign flush_o = flush;
  assign cause_o = cause_w;

  // R8
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stg_v[LAST:1] == '0));

  // R9
  bubble_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_v[LAST] |-> (!flush && !commit_o));
endmodule

// File: tb/exc_commit_ctrl_tb.sv
`timescale 1ns/1ps
module exc_commit_ctrl_tb;
  localparam logic [31:0] HPC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid_i, fetch_fault_i, dec_illegal_i, exe_ovf_i;
  logic        mem_fault_i, mem_sret_i, irq_i;
  logic [31:0] fetch_pc_i;
  logic        commit_o, flush_o, int_en_o, sup_o;
  logic [31:0] redirect_pc_o, epc_o;
  logic [2:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  exc_commit_ctrl #(.PC_W(32), .HANDLER_PC(HPC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .fetch_fault_i(fetch_fault_i), .dec_illegal_i(dec_illegal_i),
    .exe_ovf_i(exe_ovf_i), .mem_fault_i(mem_fault_i),
    .mem_sret_i(mem_sret_i), .irq_i(irq_i),
    .commit_o(commit_o), .flush_o(flush_o), .redirect_pc_o(redirect_pc_o),
    .epc_o(epc_o), .cause_o(cause_o), .int_en_o(int_en_o), .sup_o(sup_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid_i = 1'b0; fetch_pc_i = '0; fetch_fault_i = 1'b0;
    dec_illegal_i = 1'b0; exe_ovf_i = 1'b0; mem_fault_i = 1'b0;
    mem_sret_i = 1'b0; irq_i = 1'b0;
  endtask

  // One instruction alone in the pipe; flags applied in the stage that owns them.
  // Samples the commit-cycle outputs, then the registered state one cycle later.
  task automatic run_one(input logic [31:0] pc, input bit ff, input bit fd,
                         input bit fe, input bit fm, input bit irq, input bit sret,
                         output bit c_commit, output bit c_flush,
                         output logic [31:0] c_rpc);
    @(negedge clk); idle_inputs(); fetch_valid_i = 1'b1; fetch_pc_i = pc; fetch_fault_i = ff;
    @(negedge clk); idle_inputs(); dec_illegal_i = fd;
    @(negedge clk); idle_inputs(); exe_ovf_i = fe;
    @(negedge clk); idle_inputs(); mem_fault_i = fm; irq_i = irq; mem_sret_i = sret;
    #1;
    c_commit = commit_o; c_flush = flush_o; c_rpc = redirect_pc_o;
    @(negedge clk); idle_inputs();
    #1;
  endtask

  task automatic do_return(input string tag);
    bit cm, fl; logic [31:0] rp; logic [31:0] saved;
    saved = epc_o;
    run_one(32'h0000_0200, 0, 0, 0, 0, 0, 1, cm, fl, rp);
    check({tag, " R7 sret commit"}, 32'(cm), 32'd1);
    check({tag, " R7 sret flush"}, 32'(fl), 32'd1);
    check({tag, " R7 sret target"}, rp, saved);
    check({tag, " R7 int_en restored"}, 32'(int_en_o), 32'd1);
    check({tag, " R7 user mode"}, 32'(sup_o), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit cm, fl; logic [31:0] rp;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 epc", epc_o, 32'd0);
    check("R1 cause", 32'(cause_o), 32'd0);
    check("R1 int_en", 32'(int_en_o), 32'd1);
    check("R1 sup", 32'(sup_o), 32'd0);
    check("R1 commit", 32'(commit_o), 32'd0);
    check("R1 flush", 32'(flush_o), 32'd0);

    // Sweep all fault/interrupt combinations (R2, R3, R4, R5)
    for (int m = 0; m < 32; m++) begin
      bit ff, fd, fe, fm, iq, trap;
      logic [31:0] pc, ecause, old_epc, old_cause;
      string t;
      ff = m[0]; fd = m[1]; fe = m[2]; fm = m[3]; iq = m[4];
      pc = 32'h0000_1000 + 32'(m) * 4;
      trap = ff | fd | fe | fm | iq;
      ecause = iq ? 32'd5 : ff ? 32'd1 : fd ? 32'd2 : fe ? 32'd3 : fm ? 32'd4 : 32'd0;
      old_epc = epc_o; old_cause = 32'(cause_o);
      t = $sformatf("mask%0d", m);
      run_one(pc, ff, fd, fe, fm, iq, 0, cm, fl, rp);
      if (!trap) begin
        check({t, " R2 commit"}, 32'(cm), 32'd1);
        check({t, " R2 no flush"}, 32'(fl), 32'd0);
        check({t, " R2 epc kept"}, epc_o, old_epc);
        check({t, " R2 cause kept"}, 32'(cause_o), old_cause);
      end else begin
        check({t, " R5 no commit"}, 32'(cm), 32'd0);
        check({t, " R5 flush"}, 32'(fl), 32'd1);
        check({t, " R5 handler pc"}, rp, HPC);
        check({t, " R5 epc"}, epc_o, pc);
        check({t, " R5 int_en off"}, 32'(int_en_o), 32'd0);
        check({t, " R5 sup on"}, 32'(sup_o), 32'd1);
        if (iq) check({t, " R4 irq cause"}, 32'(cause_o), ecause);
        else    check({t, " R3 cause priority"}, 32'(cause_o), ecause);
        do_return(t);
      end
    end

    // R6: interrupt ignored while masked
    run_one(32'h0000_3000, 0, 1, 0, 0, 0, 0, cm, fl, rp);
    check("R6 setup cause", 32'(cause_o), 32'd2);
    run_one(32'h0000_3004, 0, 0, 0, 0, 1, 0, cm, fl, rp);
    check("R6 masked irq commits", 32'(cm), 32'd1);
    check("R6 masked irq no flush", 32'(fl), 32'd0);
    check("R6 cause unchanged", 32'(cause_o), 32'd2);
    check("R6 epc unchanged", epc_o, 32'h0000_3000);
    do_return("R6");

    // R8: older overflow traps, younger illegal is killed
    @(negedge clk); idle_inputs(); fetch_valid_i = 1'b1; fetch_pc_i = 32'h0000_4000;
    @(negedge clk); idle_inputs(); fetch_valid_i = 1'b1; fetch_pc_i = 32'h0000_4004;
    @(negedge clk); idle_inputs(); exe_ovf_i = 1'b1; dec_illegal_i = 1'b1;
    @(negedge clk); idle_inputs(); exe_ovf_i = 1'b1; // flagged against the younger one
    #1;
    check("R8 older traps", 32'(flush_o), 32'd1);
    @(negedge clk); idle_inputs(); #1;
    check("R8 younger not committed", 32'(commit_o), 32'd0);
    check("R8 younger no trap", 32'(flush_o), 32'd0);
    check("R8 cause from older", 32'(cause_o), 32'd3);
    check("R8 epc older", epc_o, 32'h0000_4000);
    do_return("R8");

    // R9: flags on bubbles do nothing
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); idle_inputs();
      fetch_fault_i = 1'b1; dec_illegal_i = 1'b1; exe_ovf_i = 1'b1;
      mem_fault_i = 1'b1; irq_i = 1'b1;
      #1;
      check("R9 bubble no flush", 32'(flush_o), 32'd0);
      check("R9 bubble no commit", 32'(commit_o), 32'd0);
    end
    @(negedge clk); idle_inputs(); #1;
    check("R9 cause untouched", 32'(cause_o), 32'd3);
    check("R9 int_en untouched", 32'(int_en_o), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule